// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit down-counter controlled through a small register interface. Software writes a start value, picks one of four tick rates and sets the run bit. The counter then loses one count on each tick of the chosen rate. When a period ends, it reloads the start value on that same tick, so the timer runs periodically. Each expiry sets a sticky flag that only a software write can clear. An active-low interrupt line either holds low while the flag is set or gives a one-cycle low pulse for each expiry.

The four tick rates reach the block as single-cycle enables in the system clock domain. The code 00 selects the fastest rate (4.096 kHz), 01 selects 64 Hz, 10 selects 1 Hz and 11 selects one tick per minute. One period lasts the loaded value divided by the selected tick frequency. A read of the value register returns the live count.

Top module: `countdown_timer`

## Requirements
- R1: After reset the control register reads 0x03 (run bit 0, source code 11), the value register reads 0x00, the status register reads 0x00 and `irq_n` is 1.
- R2: The counter advances only on `tick_en[src]`, where src is control bits [1:0]. Pulses on the other three tick inputs leave the count unchanged.
- R3: A write to the value register (address 1) loads both the start value and the live count at the next clock edge. Reads of address 1 return the live count.
- R4: With the run bit (control bit 7) set and a nonzero start value N, each selected tick lowers the count by one. The N-th tick reloads N rather than reaching 0, so every period is exactly N ticks long.
- R5: While the run bit is 0, the count holds regardless of the tick inputs.
- R6: A start value of 0 holds the counter at 0 and never sets the flag.
- R7: The flag (status bit 0, address 2) is set at the clock edge of each expiring tick and remains set. A status write with bit 0 = 0 clears it. A status write with bit 0 = 1, or any other write, leaves it unchanged. Setting has priority over clearing.
- R8: While the interrupt enable (status bit 1) is 0, `irq_n` stays 1.
- R9: With the enable set and the mode bit (status bit 2) at 0, `irq_n` is the inverse of the flag.
- R10: With the enable set and the mode bit at 1, `irq_n` goes low for exactly one clock cycle after each expiring tick's edge, whatever the flag holds.
- R11: The unused control bits 6 to 2 and the unused status bits 7 to 3 read as 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 value, 2 status |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick_en | input | 4 | Tick enables, index equals the source code |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong count or a missed reload is visible at the next read of the value register. After that it shows as a period of the wrong length, and the flag and the interrupt line change one or more ticks away from where they should. A stuck or lost flag shows up on `irq_n` in the same cycle when level mode is active. In pulse mode the error appears only at the next expiry, as a pulse that is missing or too wide. The sweep covers every source code and a range of start values in both interrupt modes, so each tick position within a period is compared against an arithmetic count.

// File: rtl/countdown_timer_pkg.sv
// Package: shared widths, register addresses and field positions for the
// countdown timer. Assumes a byte-wide register bus.
package countdown_timer_pkg;
    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int NUM_SRC  = 4;
    localparam int SRC_W    = $clog2(NUM_SRC);

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_VALUE  = 2'd1,
        REG_STATUS = 2'd2,
        REG_NONE   = 2'd3
    } reg_addr_e;

    // Control register field positions
    localparam int CTRL_RUN_BIT = 7;
    // Status register field positions
    localparam int STAT_FLAG_BIT = 0;
    localparam int STAT_IE_BIT   = 1;
    localparam int STAT_MODE_BIT = 2;

    typedef struct packed {
        logic             run;
        logic [SRC_W-1:0] src;
    } ctrl_t;

    typedef struct packed {
        logic pulse_mode;
        logic irq_en;
    } irq_cfg_t;
endpackage

// File: rtl/timer_tick_select.sv
// Tick selector: passes the enable of the selected source through.
// Assumes every tick_en bit is a single-cycle pulse in the clk domain.
module timer_tick_select #(
    parameter int NSRC = 4,
    parameter int SW   = 2
) (
    input  logic [NSRC-1:0] tick_en,
    input  logic [SW-1:0]   src,
    output logic            tick
);
    logic [NSRC-1:0] hit;

    // One AND term per source; the OR collapses the one-hot selection
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
        assign hit[gi] = tick_en[gi] && (src == SW'(gi));
    end

    assign tick = |hit;
endmodule

// File: rtl/timer_down_counter.sv
// Down-counter with reload. A software load has priority over a tick.
// The count wraps to the start value on the tick that ends a period.
// Assumes that a start value of zero parks the counter.
module timer_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] start_val,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic step;

    // A tick counts only while running, not loading, with a nonzero start
    always_comb begin
        step   = run && tick && !load_en && (start_val != '0);
        expire = step && (count <= ONE);
    end

    // Start value and live count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_val <= '0;
            count     <= '0;
        end else if (load_en) begin
            start_val <= load_val;
            count     <= load_val;
        end else if (step) begin
            count <= expire ? start_val : count - ONE;
        end
    end
endmodule

// File: rtl/timer_irq_gen.sv
// Interrupt driver: an active-low level that follows the flag, or a
// one-cycle low pulse registered from the expiry strobe.
// Assumes expire is a single-cycle strobe.
module timer_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic flag,
    input  logic irq_en,
    input  logic pulse_mode,
    output logic irq_n
);
    logic pulse_q;

    // Register the expiry so the pulse lines up with the flag update
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= expire;
    end

    // Choose level or pulse, gated by the enable
    always_comb begin
        if (!irq_en)        irq_n = 1'b1;
        else if (pulse_mode) irq_n = !pulse_q;
        else                irq_n = !flag;
    end
endmodule

// File: rtl/timer_regs.sv
// Register file: control, interrupt configuration, the sticky flag and
// the read multiplexer. Assumes one write strobe per bus transaction.
module timer_regs
    import countdown_timer_pkg::*;
#(
    parameter logic [SRC_W-1:0] RESET_SRC = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count,
    input  logic              expire,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output irq_cfg_t          cfg,
    output logic              flag,
    output logic              value_wr
);
    logic ctrl_wr;
    logic stat_wr;
    logic flag_clr;

    // Decode the write strobes per register
    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == REG_CTRL);
        value_wr = bus_wr && (bus_addr == REG_VALUE);
        stat_wr  = bus_wr && (bus_addr == REG_STATUS);
        flag_clr = stat_wr && !bus_wdata[STAT_FLAG_BIT];
    end

    // Control register: run bit and tick source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.run <= 1'b0;
            ctrl.src <= RESET_SRC;
        end else if (ctrl_wr) begin
            ctrl.run <= bus_wdata[CTRL_RUN_BIT];
            ctrl.src <= bus_wdata[SRC_W-1:0];
        end
    end

    // Interrupt configuration bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (stat_wr) begin
            cfg.irq_en     <= bus_wdata[STAT_IE_BIT];
            cfg.pulse_mode <= bus_wdata[STAT_MODE_BIT];
        end
    end

    // Sticky flag: set wins over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (expire)   flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    // Read multiplexer; unused bits return zero
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTRL_RUN_BIT] = ctrl.run;
                bus_rdata[SRC_W-1:0]    = ctrl.src;
            end
            REG_VALUE:  bus_rdata = count;
            REG_STATUS: begin
                bus_rdata[STAT_FLAG_BIT] = flag;
                bus_rdata[STAT_IE_BIT]   = cfg.irq_en;
                bus_rdata[STAT_MODE_BIT] = cfg.pulse_mode;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/countdown_timer.sv
// Top: programmable countdown timer with a sticky flag and an active-low
// interrupt. Assumes the tick enables come from a prescaler elsewhere,
// synchronous to clk, one cycle wide.
module countdown_timer
    import countdown_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] tick_en,
    output logic              irq_n
);
    ctrl_t             ctrl;
    irq_cfg_t          cfg;
    logic              flag;
    logic              value_wr;
    logic              tick;
    logic              expire;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] start_val;

    timer_regs #(.RESET_SRC(2'b11)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .count     (count),
        .expire    (expire),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .cfg       (cfg),
        .flag      (flag),
        .value_wr  (value_wr)
    );

    timer_tick_select #(.NSRC(NUM_SRC), .SW(SRC_W)) u_sel (
        .tick_en (tick_en),
        .src     (ctrl.src),
        .tick    (tick)
    );

    timer_down_counter #(.W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (value_wr),
        .load_val  (bus_wdata),
        .run       (ctrl.run),
        .tick      (tick),
        .count     (count),
        .start_val (start_val),
        .expire    (expire)
    );

    timer_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .flag       (flag),
        .irq_en     (cfg.irq_en),
        .pulse_mode (cfg.pulse_mode),
        .irq_n      (irq_n)
    );
endmodule

// File: rtl/countdown_timer_chk.sv
// Checker: temporal properties of the countdown timer, bound to the top.
module countdown_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       value_wr,
    input logic [7:0] bus_wdata,
    input logic       stat_clr,
    input logic       run,
    input logic [7:0] count,
    input logic [7:0] start_val,
    input logic       expire,
    input logic       flag,
    input logic       irq_en,
    input logic       pulse_mode,
    input logic       irq_n
);
    // R3: a value write shows up as the live count one edge later
    a_r3_load_now: assert property (@(posedge clk) disable iff (!rst_n)
        value_wr |=> (count == $past(bus_wdata)));

    // R5: a stopped counter does not move unless software loads it
    a_r5_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !value_wr) |=> (count == $past(count)));

    // R6: a zero start value never produces an expiry
    a_r6_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start_val == 8'd0) |-> !expire);

    // R7: the flag stays set unless a clearing status write arrives
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_clr) |=> flag);

    // R7: every expiry leaves the flag set
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    // R8: disabled interrupt keeps the line high
    a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> irq_n);

    // R10: a low pulse in pulse mode always follows an expiry
    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && pulse_mode && !irq_n) |-> $past(expire));
endmodule

bind countdown_timer countdown_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .value_wr   (value_wr),
    .bus_wdata  (bus_wdata),
    .stat_clr   (bus_wr && (bus_addr == 2'd2) && !bus_wdata[0]),
    .run        (ctrl.run),
    .count      (count),
    .start_val  (start_val),
    .expire     (expire),
    .flag       (flag),
    .irq_en     (cfg.irq_en),
    .pulse_mode (cfg.pulse_mode),
    .irq_n      (irq_n)
);

// File: tb/test_countdown_timer.sv
module test_countdown_timer;
    localparam time CLK_PERIOD = 10ns;
    localparam int  MAX_N      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [3:0] tick_en = 4'd0;
    logic       irq_n;

    int n_chk  = 0;
    int n_fail = 0;

    countdown_timer i_countdown_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .irq_n     (irq_n)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int idx);
        tick_en = 4'(1 << idx);
        step();
        tick_en = 4'd0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hang is a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd(2'd0, d); check("R1 ctrl", d, 8'h03);
        rd(2'd1, d); check("R1 value", d, 8'h00);
        rd(2'd2, d); check("R1 status", d, 8'h00);
        check("R1 irq_n", irq_n, 1);

        // R11: unused bits read back as zero
        wr(2'd0, 8'hFE); rd(2'd0, d); check("R11 ctrl unused", d, 8'h82);
        wr(2'd2, 8'hF8); rd(2'd2, d); check("R11 status unused", d, 8'h00);
        rd(2'd3, d); check("R11 addr3", d, 8'h00);
        wr(2'd0, 8'h00);

        // R5: stopped counter ignores every tick input
        wr(2'd1, 8'd9);
        for (int i = 0; i < 4; i++) tick(i);
        rd(2'd1, d); check("R5 hold", d, 9);

        // R6: zero start value never expires
        wr(2'd1, 8'd0); wr(2'd0, 8'h80);
        for (int i = 0; i < 6; i++) tick(0);
        rd(2'd1, d); check("R6 count", d, 0);
        rd(2'd2, d); check("R6 flag", d, 8'h00);

        // Sweep every source and start values 1..MAX_N in both modes
        for (int s = 0; s < 4; s++) begin
            for (int n = 1; n <= MAX_N; n++) begin
                logic pm;
                pm = n[0];
                wr(2'd0, 8'(s));
                wr(2'd2, {5'd0, pm, 1'b1, 1'b0});
                wr(2'd1, 8'(n));
                rd(2'd1, d); check("R3 load", d, n);
                wr(2'd0, 8'(8'h80 | s));
                for (int k = 1; k < n; k++) begin
                    tick((s + 1) % 4);
                    rd(2'd1, d); check("R2 other src", d, n - k + 1);
                    tick(s);
                    rd(2'd1, d); check("R4 count", d, n - k);
                    check("R7 flag clear", d == 0 ? 0 : 1, 1);
                    check("R9/R10 irq idle", irq_n, 1);
                end
                tick(s);
                rd(2'd1, d); check("R4 reload", d, n);
                rd(2'd2, d); check("R7 flag set", d[0], 1);
                check(pm ? "R10 pulse low" : "R9 level low", irq_n, 0);
                step();
                check(pm ? "R10 pulse one cycle" : "R9 level held", irq_n, pm ? 1 : 0);
            end
        end

        // R4: a second full period with start value 3
        wr(2'd0, 8'h00); wr(2'd2, 8'h00);
        wr(2'd1, 8'd3); wr(2'd0, 8'h82);
        for (int k = 0; k < 6; k++) tick(2);
        rd(2'd1, d); check("R4 second period", d, 3);

        // R7: writing 1 keeps the flag; another register write keeps it
        wr(2'd2, 8'h01); rd(2'd2, d); check("R7 write one keeps", d, 8'h01);
        wr(2'd0, 8'h02); rd(2'd2, d); check("R7 ctrl write keeps", d, 8'h01);
        // R8: enable off while flag set keeps irq_n high
        check("R8 irq idle", irq_n, 1);
        wr(2'd2, 8'h03); check("R9 level follows flag", irq_n, 0);
        wr(2'd2, 8'h02); check("R9 cleared flag", irq_n, 1);
        rd(2'd2, d); check("R7 cleared", d, 8'h02);

        // R7: set wins over a clear in the same cycle (start value 1)
        wr(2'd1, 8'd1); wr(2'd0, 8'h80);
        bus_addr = 2'd2; bus_wdata = 8'h00; bus_wr = 1'b1; tick_en = 4'b0001;
        step();
        bus_wr = 1'b0; tick_en = 4'd0;
        rd(2'd2, d); check("R7 set priority", d[0], 1);

        // R2: full mask of ticks on a non-selected source only
        wr(2'd1, 8'd5); wr(2'd0, 8'h83);
        for (int i = 0; i < 3; i++) tick(i);
        rd(2'd1, d); check("R2 unselected", d, 5);

        finish_run();
    end
endmodule